// File: doc/BRIEF.md
# Auto-Increment Register Window Bridge

The bridge lets a host with 16-bit registers reach a byte-wide bus that has a 16-bit address space. The host sees four registers, picked by a two-bit select: a window pointer, a byte data port, a halfword data port, and a write-only port that carries an address byte and a data byte in one word. Each host access becomes zero, one or two byte cycles on the bus. Every bus cycle uses a request/acknowledge handshake.

Streaming through the window needs no pointer rewrites. Each data-port access moves the pointer past the bytes it touched. The paired port reaches any location inside the current 256-byte page in a single host write and leaves the pointer untouched. The host holds `host_req` and its command until `host_ack` pulses. It drops the request on the cycle it sees the pulse.

The sequencer has four states:
- `ST_IDLE` waits for a host request.
- `ST_LO` runs the first (or only) bus cycle.
- `ST_HI` runs the second byte of a halfword access.
- `ST_DONE` presents the result for one cycle.

Transitions:
- IDLE to DONE: a pointer access, or a read of the paired port.
- IDLE to LO: any other request.
- LO to HI: a halfword access, on acknowledge.
- LO to DONE: any other access, on acknowledge.
- HI to DONE: on acknowledge.
- DONE to IDLE: always.

Top module: `winbr_top`

## Requirements
- R1: After reset the window pointer reads 0x0000, and `bus_req` and `host_ack` are low.
- R2: Select 0 reads or writes the window pointer. It starts no bus cycle, and a read returns the value the pointer held when the access was accepted.
- R3: Select 1 runs one bus cycle at the pointer address, using data bits 7..0. A read returns the byte in bits 7..0 with bits 15..8 zero. The pointer then grows by 1.
- R4: Select 2 runs two bus cycles: first at the pointer, then at pointer+1. Host bits 7..0 pair with the lower address and bits 15..8 with the upper one, for both reads and writes. The pointer then grows by 2.
- R5: A write to select 3 runs one bus write. The bus address is pointer bits 15..8 followed by host bits 15..8, and the bus data is host bits 7..0. The pointer is unchanged.
- R6: A read of select 3 starts no bus cycle and returns 0x0000.
- R7: Pointer arithmetic and the second-byte address wrap modulo 2^16: 0xFFFF + 1 gives 0x0000.
- R8: `host_ack` is a one-cycle pulse. For any access that uses the bus, it comes only after the acknowledge of the last bus cycle, so the host is stalled for the whole bus latency.
- R9: While `bus_req` is high and unacknowledged, `bus_addr`, `bus_wdata` and `bus_we` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 pointer, 1 byte port, 2 halfword port, 3 paired write port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read result, valid while `host_ack` is high |
| host_ack | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus cycle request, held until `bus_ack` |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | 16 | Bus byte address |
| bus_wdata | output | 8 | Bus write byte |
| bus_rdata | input | 8 | Bus read byte, sampled with `bus_ack` |
| bus_ack | input | 1 | Bus cycle completion |

## Verification
The bus responder returns a byte that mixes both halves of the address. Any mix-up between the two address bytes, or any swap of the two halves of a halfword read, therefore shows up as a wrong value.

A scripted sequence runs each select with reads and writes. It mixes accesses that advance the pointer with ones that must leave it alone, and it reads the pointer back after every step. This separates the +1, +2 and no-change cases. Halfword and byte accesses start at 0xFFFF to exercise the wrap. A second pass stretches the bus latency, which shows whether the host completion waits for every bus acknowledge.

// File: rtl/winbr_pkg.sv
package winbr_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_BYTE = 2'd1,
        SEL_WORD = 2'd2,
        SEL_PAIR = 2'd3
    } port_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

endpackage

// File: rtl/winbr_ptr.sv
module winbr_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    input  logic          step2,
    output logic [AW-1:0] q
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] q_next;

    always_comb begin
        q_next = q;
        if (ld) begin
            q_next = ld_val;
        end else if (inc) begin
            q_next = q + (step2 ? TWO : ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    // R5 / R6: the pointer holds when neither loaded nor advanced.
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc) |=> $stable(q));

    // R3 / R7: single-step advance, modulo 2^AW.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && inc && !step2) |=> (q == $past(q) + ONE));

    // R4 / R7: double-step advance, modulo 2^AW.
    a_r4_step_two: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && inc && step2) |=> (q == $past(q) + TWO));

endmodule

// File: rtl/winbr_lane.sv
module winbr_lane
    import winbr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  port_sel_t       sel,
    input  logic            beat_hi,
    input  logic [AW-1:0]   win,
    input  logic [2*DW-1:0] cmd_wdata,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   wdata
);
    localparam int HW = 2 * DW;

    always_comb begin
        if (beat_hi) begin
            addr  = win + AW'(1);
            wdata = cmd_wdata[HW-1:DW];
        end else if (sel == SEL_PAIR) begin
            addr  = {win[AW-1:DW], cmd_wdata[HW-1:DW]};
            wdata = cmd_wdata[DW-1:0];
        end else begin
            addr  = win;
            wdata = cmd_wdata[DW-1:0];
        end
    end

endmodule

// File: rtl/winbr_seq.sv
module winbr_seq
    import winbr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [1:0]      host_sel,
    input  logic [2*DW-1:0] host_wdata,
    output logic [2*DW-1:0] host_rdata,
    output logic            host_ack,
    output logic            bus_req,
    output logic            bus_we,
    input  logic            bus_ack,
    input  logic [DW-1:0]   bus_rdata,
    input  logic [AW-1:0]   win,
    output port_sel_t       cmd_sel,
    output logic [2*DW-1:0] cmd_wdata,
    output logic            beat_hi,
    output logic            ptr_ld,
    output logic            ptr_inc,
    output logic            ptr_step2
);
    localparam int HW = 2 * DW;

    seq_state_t    state, state_nx;
    logic          cmd_we;
    logic [AW-1:0] cmd_ptr;
    logic [DW-1:0] rd_lo, rd_hi;
    port_sel_t     req_sel;
    logic          accept;
    logic          no_bus;

    assign req_sel = port_sel_t'(host_sel);
    assign accept  = (state == ST_IDLE) && host_req;
    assign no_bus  = (req_sel == SEL_PTR) || ((req_sel == SEL_PAIR) && !host_we);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (host_req) state_nx = no_bus ? ST_DONE : ST_LO;
            ST_LO:   if (bus_ack)  state_nx = (cmd_sel == SEL_WORD) ? ST_HI : ST_DONE;
            ST_HI:   if (bus_ack)  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req   = 1'b0;
        host_ack  = 1'b0;
        beat_hi   = 1'b0;
        ptr_inc   = 1'b0;
        ptr_step2 = 1'b0;
        ptr_ld    = accept && host_we && (req_sel == SEL_PTR);
        unique case (state)
            ST_IDLE: ;
            ST_LO: begin
                bus_req = 1'b1;
                ptr_inc = bus_ack && (cmd_sel == SEL_BYTE);
            end
            ST_HI: begin
                bus_req   = 1'b1;
                beat_hi   = 1'b1;
                ptr_inc   = bus_ack;
                ptr_step2 = 1'b1;
            end
            ST_DONE: host_ack = 1'b1;
        endcase
    end

    assign bus_we = cmd_we;

    // Command capture and read-data gathering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_we    <= 1'b0;
            cmd_sel   <= SEL_PTR;
            cmd_wdata <= '0;
            cmd_ptr   <= '0;
            rd_lo     <= '0;
            rd_hi     <= '0;
        end else begin
            if (accept) begin
                cmd_we    <= host_we;
                cmd_sel   <= req_sel;
                cmd_wdata <= host_wdata;
                cmd_ptr   <= win;
                rd_lo     <= '0;
                rd_hi     <= '0;
            end
            if ((state == ST_LO) && bus_ack) rd_lo <= bus_rdata;
            if ((state == ST_HI) && bus_ack) rd_hi <= bus_rdata;
        end
    end

    always_comb begin
        unique case (cmd_sel)
            SEL_PTR:  host_rdata = HW'(cmd_ptr);
            SEL_BYTE: host_rdata = {{DW{1'b0}}, rd_lo};
            SEL_WORD: host_rdata = {rd_hi, rd_lo};
            SEL_PAIR: host_rdata = '0;
        endcase
    end

    // R8: completion is a single-cycle pulse.
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R8: a bus-using access completes only right after a bus acknowledge.
    a_r8_ack_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && (cmd_sel != SEL_PTR) && !((cmd_sel == SEL_PAIR) && !cmd_we))
            |-> $past(bus_ack));

    // R9: bus command held while waiting for the acknowledge.
    a_r9_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we)));

    // R6: a paired-port read never starts a bus cycle.
    a_r6_pair_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_sel == SEL_PAIR) && !host_we) |=> !bus_req);

    // R1: leaving reset, nothing is requested.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !host_ack));

endmodule

// File: rtl/winbr_top.sv
module winbr_top
    import winbr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [1:0]      host_sel,
    input  logic [2*DW-1:0] host_wdata,
    output logic [2*DW-1:0] host_rdata,
    output logic            host_ack,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack
);
    localparam int HW = 2 * DW;

    logic [AW-1:0] win;
    port_sel_t     cmd_sel;
    logic [HW-1:0] cmd_wdata;
    logic          beat_hi, ptr_ld, ptr_inc, ptr_step2;

    winbr_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_ack   (host_ack),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .win        (win),
        .cmd_sel    (cmd_sel),
        .cmd_wdata  (cmd_wdata),
        .beat_hi    (beat_hi),
        .ptr_ld     (ptr_ld),
        .ptr_inc    (ptr_inc),
        .ptr_step2  (ptr_step2)
    );

    winbr_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ptr_ld),
        .ld_val (AW'(host_wdata)),
        .inc    (ptr_inc),
        .step2  (ptr_step2),
        .q      (win)
    );

    winbr_lane #(.AW(AW), .DW(DW)) u_lane (
        .sel       (cmd_sel),
        .beat_hi   (beat_hi),
        .win       (win),
        .cmd_wdata (cmd_wdata),
        .addr      (bus_addr),
        .wdata     (bus_wdata)
    );

    // R9: address and write byte hold while a bus cycle waits.
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: tb/sim_winbr_top.sv
module sim_winbr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_ack;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h0;
    logic        bus_ack = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int lat = 1;
    int beats = 0;
    int cnt = 0;
    logic [15:0] last_addr = 16'h0;
    logic [7:0]  last_wd = 8'h0;
    int cycles_total = 0;

    always #4 clk = ~clk;

    winbr_top u0 (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'd1;
    endfunction

    // Bus responder with programmable latency
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0;
            cnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            cnt = 0;
        end else if (bus_req) begin
            if (cnt >= lat) begin
                bus_ack   = 1'b1;
                bus_rdata = mem_byte(bus_addr);
                beats++;
                last_addr = bus_addr;
                if (bus_we) last_wd = bus_wdata;
            end else begin
                cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] sel, input logic [15:0] wd,
                          output logic [15:0] rd, output int cyc);
        @(negedge clk);
        beats = 0;
        host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ack && cyc < 500);
        if (!host_ack) chk("R8 watchdog on host_ack", 0, 1);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [15:0] wd;
        logic [15:0] exp_rd;
        logic [3:0]  exp_beats;
        logic [15:0] exp_last;
        logic [7:0]  exp_wd;
        logic [15:0] exp_win;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 16'h1234, 16'h0000, 4'd0, 16'h0000, 8'h00, 16'h1234}, // R2 write ptr
        '{1'b0, 2'd0, 16'h0000, 16'h1234, 4'd0, 16'h0000, 8'h00, 16'h1234}, // R2 read ptr
        '{1'b0, 2'd1, 16'h0000, 16'h0047, 4'd1, 16'h1234, 8'h00, 16'h1235}, // R3 byte read
        '{1'b0, 2'd2, 16'h0000, 16'h4948, 4'd2, 16'h1236, 8'h00, 16'h1237}, // R4 word read
        '{1'b1, 2'd1, 16'h00AB, 16'h0000, 4'd1, 16'h1237, 8'hAB, 16'h1238}, // R3 byte write
        '{1'b1, 2'd2, 16'hBEEF, 16'h0000, 4'd2, 16'h1239, 8'hBE, 16'h123A}, // R4 word write
        '{1'b1, 2'd3, 16'h77C3, 16'h0000, 4'd1, 16'h1277, 8'hC3, 16'h123A}, // R5 paired write
        '{1'b0, 2'd3, 16'h0000, 16'h0000, 4'd0, 16'h0000, 8'h00, 16'h123A}, // R6 paired read
        '{1'b1, 2'd0, 16'hFFFF, 16'h0000, 4'd0, 16'h0000, 8'h00, 16'hFFFF}, // R2
        '{1'b0, 2'd1, 16'h0000, 16'h00FF, 4'd1, 16'hFFFF, 8'h00, 16'h0000}, // R7 byte wrap
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 4'd0, 16'h0000, 8'h00, 16'h0000}, // R7 readback
        '{1'b1, 2'd0, 16'hFFFF, 16'h0000, 4'd0, 16'h0000, 8'h00, 16'hFFFF}, // R2
        '{1'b0, 2'd2, 16'h0000, 16'h01FF, 4'd2, 16'h0000, 8'h00, 16'h0001}, // R7 word wrap
        '{1'b1, 2'd3, 16'h1055, 16'h0000, 4'd1, 16'h0010, 8'h55, 16'h0001}  // R5 paired write
    };

    // Watchdog
    always @(posedge clk) begin
        cycles_total++;
        if (cycles_total > 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles_total);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int cyc;

        repeat (3) @(negedge clk);
        chk("R1 bus_req low in reset", bus_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 host_ack low after reset", host_ack, 0);
        chk("R1 bus_req low after reset", bus_req, 0);
        access(1'b0, 2'd0, 16'h0, rd, cyc);
        chk("R1 pointer reset value", rd, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            access(v.we, v.sel, v.wd, rd, cyc);
            if (!v.we) chk($sformatf("vec %0d read data (R2 R3 R4 R6)", i), rd, v.exp_rd);
            chk($sformatf("vec %0d bus beats (R2 R3 R4 R5 R6)", i), beats, v.exp_beats);
            if (v.exp_beats != 0)
                chk($sformatf("vec %0d last bus address (R3 R4 R5 R7)", i), last_addr, v.exp_last);
            if (v.we && v.exp_beats != 0)
                chk($sformatf("vec %0d last bus write byte (R4 R5)", i), last_wd, v.exp_wd);
            access(1'b0, 2'd0, 16'h0, rd, cyc);
            chk($sformatf("vec %0d pointer after (R3 R4 R5 R7)", i), rd, v.exp_win);
        end

        // R8: long bus latency stalls the host through both beats
        lat = 4;
        access(1'b1, 2'd0, 16'h2000, rd, cyc);
        access(1'b0, 2'd2, 16'h0, rd, cyc);
        chk("R8 word read data under latency", rd, {mem_byte(16'h2001), mem_byte(16'h2000)});
        chk("R8 both beats done before ack", beats, 2);
        chk("R8 host stalled for bus latency", (cyc >= 2 * lat) ? 1 : 0, 1);
        access(1'b1, 2'd1, 16'h0011, rd, cyc);
        chk("R8 byte write beats under latency", beats, 1);
        chk("R8 byte write address", last_addr, 16'h2002);
        lat = 0;
        access(1'b0, 2'd1, 16'h0, rd, cyc);
        chk("R3 zero-latency byte read", rd, {8'h00, mem_byte(16'h2003)});
        access(1'b0, 2'd0, 16'h0, rd, cyc);
        chk("R3 pointer after zero-latency read", rd, 16'h2004);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule